// File: doc/BRIEF.md
# NAND ECC Geometry Calculator

This block works out the error-correction layout of a NAND page that is protected by a BCH code. The host supplies two byte counts: the size of the page data area and the size of the spare area. The block splits the data area into 512-byte chunks. It then finds the largest even correction strength whose parity fits into the spare area, after 10 bytes are set aside for metadata. Each correction level costs 13 parity bits per chunk.

A page is stored as metadata followed by data chunks, with each chunk's parity placed right after it. Because of this interleaving, the factory bad-block marker no longer sits at the byte where the plain page layout puts it. The block maps that conventional marker position into the interleaved layout and reports where the marker lands in the data buffer, as a byte offset and a bit offset. If the marker falls inside a parity region, the position is forced to a fixed value and a flag is raised.

A request is made by pulsing `start_i`. One iterative divider, shared by both divisions, does the arithmetic one quotient bit per cycle. A single-cycle `done_o` pulse marks the end of the computation, and the results then stay unchanged until the next accepted request.

Top module: `nand_ecc_geom`

## Requirements
- R1: `chunks_o` equals the page data byte count divided by 512, truncated.
- R2: `strength_o` equals ((spare − 10) × 8) / (13 × chunks), truncated and then rounded down to an even number. A spare count below 10 gives a strength of 0.
- R3: The marker bit position starts at page × 8 − 80. Its chunk index is that position divided by (4096 + 13 × strength), and its in-chunk offset is what is left after removing index × (4096 + 13 × strength).
- R4: When the in-chunk offset is 4096 or less, the final bit position is the starting position minus index × 13 × strength. `mark_byte_o` is that position divided by 8, and `mark_bit_o` is its low 3 bits.
- R5: When the in-chunk offset exceeds 4096, the final position is 1 (`mark_byte_o`=0, `mark_bit_o`=1) and `mark_in_ecc_o` is 1. Otherwise `mark_in_ecc_o` is 0.
- R6: A page count that yields zero chunks sets `err_o`=1 and drives `chunks_o`, `strength_o`, `mark_byte_o`, `mark_bit_o` and `mark_in_ecc_o` to 0. In that case `done_o` pulses on the cycle after the start and no division is run. A successful computation clears `err_o`.
- R7: `done_o` is high for exactly one cycle per accepted request. `busy_o` is high from the cycle after an accepted non-error start until `done_o`.
- R8: A `start_i` pulse while `busy_o` is high is ignored, and the results reflect the inputs of the earlier accepted request.
- R9: All result outputs hold their values from `done_o` until the next accepted start, whatever the inputs do in between.
- R10: After reset, `busy_o`, `done_o`, `err_o` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted only when idle |
| page_bytes_i | input | 16 | Page data area size in bytes |
| spare_bytes_i | input | 16 | Spare area size in bytes |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Zero chunk count in the last request |
| chunks_o | output | 7 | Number of 512-byte chunks |
| strength_o | output | 16 | Even correction strength |
| mark_byte_o | output | 16 | Marker byte offset in the data buffer |
| mark_bit_o | output | 3 | Marker bit offset within that byte |
| mark_in_ecc_o | output | 1 | Marker position falls inside a parity region |

## Verification
The hardest case to reach from the ports is a marker that lands inside a parity region. With ordinary spare sizes the chunk stride stays small enough that the marker always falls in data. Reaching the other case takes a 1024-byte page with a spare area so large (1018 bytes) that the strength reaches 310. At that strength the first chunk grows past the whole starting position, and the in-chunk offset ends up above 4096. The bench drives exactly that geometry. It also drives a second start in the middle of a division, with different operands, to show that the busy guard keeps the first request's results.

// File: rtl/nand_ecc_geom_pkg.sv
package nand_ecc_geom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_D1_GO,
    ST_D1_WAIT,
    ST_D2_GO,
    ST_D2_WAIT
  } geom_state_e;
endpackage

// File: rtl/geom_divider.sv
module geom_divider #(
  parameter int NUM_W = 19,
  parameter int DEN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o,
  output logic [DEN_W-1:0] rem_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] acc_q;
  logic [DEN_W-1:0] rem_q, den_q, rem_nxt;
  logic [DEN_W:0]   rem_sh;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, q_bit;

  always_comb begin
    rem_sh  = {rem_q, acc_q[NUM_W-1]};
    q_bit   = rem_sh >= {1'b0, den_q};
    rem_nxt = q_bit ? DEN_W'(rem_sh - {1'b0, den_q}) : DEN_W'(rem_sh);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      acc_q  <= num_i;
      rem_q  <= '0;
      den_q  <= den_i;
      cnt_q  <= CNT_W'(NUM_W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      acc_q  <= {acc_q[NUM_W-2:0], q_bit};
      rem_q  <= rem_nxt;
      cnt_q  <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = acc_q;
  assign rem_o  = rem_q;

  // R3: partial remainder always below the divisor
  p_rem_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (rem_q < den_q));

  p_div_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/geom_mark_map.sv
module geom_mark_map #(
  parameter int NUM_W      = 19,
  parameter int DEN_W      = 20,
  parameter int CHUNK_BITS = 4096
) (
  input  logic [NUM_W-1:0] idx_i,
  input  logic [DEN_W-1:0] rem_i,
  output logic [NUM_W-4:0] byte_o,
  output logic [2:0]       bit_o,
  output logic             in_ecc_o
);
  localparam int IDX_SHIFT = $clog2(CHUNK_BITS);

  logic [NUM_W-1:0] fin;

  // pos - idx*lvl_bits*s == rem + idx*CHUNK_BITS
  always_comb begin
    in_ecc_o = rem_i > DEN_W'(CHUNK_BITS);
    if (in_ecc_o) fin = NUM_W'(1);
    else          fin = NUM_W'(rem_i) + (idx_i << IDX_SHIFT);
    byte_o = fin[NUM_W-1:3];
    bit_o  = fin[2:0];
  end
endmodule

// File: rtl/nand_ecc_geom.sv
module nand_ecc_geom
  import nand_ecc_geom_pkg::*;
#(
  parameter int PAGE_W      = 16,
  parameter int CHUNK_BYTES = 512,
  parameter int META_BYTES  = 10,
  parameter int LVL_BITS    = 13
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    start_i,
  input  logic [PAGE_W-1:0]                       page_bytes_i,
  input  logic [PAGE_W-1:0]                       spare_bytes_i,
  output logic                                    busy_o,
  output logic                                    done_o,
  output logic                                    err_o,
  output logic [PAGE_W-$clog2(CHUNK_BYTES)-1:0]   chunks_o,
  output logic [PAGE_W-1:0]                       strength_o,
  output logic [PAGE_W-1:0]                       mark_byte_o,
  output logic [2:0]                              mark_bit_o,
  output logic                                    mark_in_ecc_o
);
  localparam int CHUNK_SHIFT = $clog2(CHUNK_BYTES);
  localparam int CNT_W       = PAGE_W - CHUNK_SHIFT;
  localparam int NUM_W       = PAGE_W + 3;
  localparam int DEN_W       = PAGE_W + 4;
  localparam int CHUNK_BITS  = CHUNK_BYTES * 8;

  geom_state_e      state_q;
  logic [PAGE_W-1:0] page_q, spare_q, str_q;
  logic [CNT_W-1:0]  chunks_w;
  logic [NUM_W-1:0]  num1, pos_w, div_num, div_quo;
  logic [DEN_W-1:0]  den1, den2, div_den, div_rem;
  logic              div_start, div_done;
  logic [PAGE_W-1:0] map_byte;
  logic [2:0]        map_bit;
  logic              map_ecc;

  logic              err_q, done_q, ecc_q;
  logic [CNT_W-1:0]  chunks_q;
  logic [PAGE_W-1:0] str_out_q, byte_q;
  logic [2:0]        bit_q;

  always_comb begin
    chunks_w = page_q[PAGE_W-1:CHUNK_SHIFT];
    num1     = (spare_q < PAGE_W'(META_BYTES)) ? '0
             : {spare_q - PAGE_W'(META_BYTES), 3'b000};
    den1     = DEN_W'(LVL_BITS) * DEN_W'(chunks_w);
    pos_w    = {page_q, 3'b000} - NUM_W'(META_BYTES * 8);
    den2     = DEN_W'(CHUNK_BITS) + DEN_W'(LVL_BITS) * DEN_W'(str_q);
    div_start = (state_q == ST_D1_GO) || (state_q == ST_D2_GO);
    div_num   = (state_q == ST_D1_GO) ? num1 : pos_w;
    div_den   = (state_q == ST_D1_GO) ? den1 : den2;
  end

  geom_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (div_num),
    .den_i   (div_den),
    .done_o  (div_done),
    .quo_o   (div_quo),
    .rem_o   (div_rem)
  );

  geom_mark_map #(.NUM_W(NUM_W), .DEN_W(DEN_W), .CHUNK_BITS(CHUNK_BITS)) u_map (
    .idx_i    (div_quo),
    .rem_i    (div_rem),
    .byte_o   (map_byte),
    .bit_o    (map_bit),
    .in_ecc_o (map_ecc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      page_q    <= '0;
      spare_q   <= '0;
      str_q     <= '0;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
      ecc_q     <= 1'b0;
      chunks_q  <= '0;
      str_out_q <= '0;
      byte_q    <= '0;
      bit_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          page_q  <= page_bytes_i;
          spare_q <= spare_bytes_i;
          if (page_bytes_i[PAGE_W-1:CHUNK_SHIFT] == '0) begin
            err_q     <= 1'b1;
            chunks_q  <= '0;
            str_out_q <= '0;
            byte_q    <= '0;
            bit_q     <= '0;
            ecc_q     <= 1'b0;
            done_q    <= 1'b1;
          end else begin
            state_q <= ST_D1_GO;
          end
        end
        ST_D1_GO: state_q <= ST_D1_WAIT;
        ST_D1_WAIT: if (div_done) begin
          str_q   <= PAGE_W'(div_quo) & ~PAGE_W'(1);
          state_q <= ST_D2_GO;
        end
        ST_D2_GO: state_q <= ST_D2_WAIT;
        ST_D2_WAIT: if (div_done) begin
          err_q     <= 1'b0;
          chunks_q  <= chunks_w;
          str_out_q <= str_q;
          byte_q    <= map_byte;
          bit_q     <= map_bit;
          ecc_q     <= map_ecc;
          done_q    <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = state_q != ST_IDLE;
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign chunks_o      = chunks_q;
  assign strength_o    = str_out_q;
  assign mark_byte_o   = byte_q;
  assign mark_bit_o    = bit_q;
  assign mark_in_ecc_o = ecc_q;

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_ignore_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(page_q) && $stable(spare_q)));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(strength_o) && $stable(mark_byte_o)
                               && $stable(mark_bit_o) && $stable(chunks_o)
                               && $stable(err_o) && $stable(mark_in_ecc_o)));

  p_err_chunks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (chunks_o == '0 && strength_o == '0));

  p_forced_pos_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mark_in_ecc_o) |-> (mark_byte_o == '0 && mark_bit_o == 3'd1));
endmodule

// File: tb/tb_nand_ecc_geom.sv
`timescale 1ns/1ps
module tb_nand_ecc_geom;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] page = '0, spare = '0;
  logic        busy, done, err, in_ecc;
  logic [6:0]  chunks;
  logic [15:0] strength, mbyte;
  logic [2:0]  mbit;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  nand_ecc_geom dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .page_bytes_i(page), .spare_bytes_i(spare),
    .busy_o(busy), .done_o(done), .err_o(err), .chunks_o(chunks),
    .strength_o(strength), .mark_byte_o(mbyte), .mark_bit_o(mbit),
    .mark_in_ecc_o(in_ecc)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference from the requirements
  task automatic model(input int pg, input int sp, output int ch, output int st,
                       output int by, output int bi, output int fl, output int er);
    int pos, den, idx, rem, fin;
    ch = pg / 512;
    er = (ch == 0);
    st = 0; by = 0; bi = 0; fl = 0;
    if (!er) begin
      st = (sp < 10) ? 0 : ((sp - 10) * 8) / (13 * ch);
      st = st - (st % 2);
      pos = pg * 8 - 80;
      den = 4096 + 13 * st;
      idx = pos / den;
      rem = pos - idx * den;
      if (rem > 4096) begin fin = 1; fl = 1; end
      else fin = pos - idx * 13 * st;
      by = fin / 8;
      bi = fin % 8;
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (!done) chk("R7 watchdog", 0, 1);
  endtask

  task automatic launch(input int pg, input int sp);
    page = 16'(pg); spare = 16'(sp); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_outputs(input int pg, input int sp, input string tag);
    int ch, st, by, bi, fl, er;
    model(pg, sp, ch, st, by, bi, fl, er);
    chk({tag, " R1 chunks"}, int'(chunks), ch);
    chk({tag, " R2 strength"}, int'(strength), st);
    chk({tag, " R4 byte"}, int'(mbyte), by);
    chk({tag, " R4 bit"}, int'(mbit), bi);
    chk({tag, " R5 flag"}, int'(in_ecc), fl);
    chk({tag, " R6 err"}, int'(err), er);
  endtask

  task automatic run_case(input int pg, input int sp, input string tag);
    launch(pg, sp);
    wait_done();
    check_outputs(pg, sp, tag);
    @(negedge clk);
    chk({tag, " R7 done pulse"}, int'(done), 0);
  endtask

  task automatic t_reset();
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 err", int'(err), 0);
    chk("R10 strength", int'(strength), 0);
    chk("R10 byte", int'(mbyte), 0);
    chk("R10 flag", int'(in_ecc), 0);
  endtask

  task automatic t_known();
    run_case(2048, 64, "known");
    chk("R4 abs byte 2048/64", int'(mbyte), 1999);
    chk("R2 abs strength 2048/64", int'(strength), 8);
    run_case(2048, 128, "odd bit");
    chk("R4 abs bit 2048/128", int'(mbit), 2);
    run_case(4096, 128, "even round");
    chk("R2 abs round 4096/128", int'(strength), 8);
    run_case(4096, 224, "4k");
    run_case(8192, 448, "8k");
    run_case(2048, 4, "small spare");
  endtask

  task automatic t_in_ecc();
    run_case(1024, 1018, "in_ecc");
    chk("R5 abs flag", int'(in_ecc), 1);
    chk("R5 abs bit", int'(mbit), 1);
    run_case(2048, 64, "flag clears");
  endtask

  task automatic t_err();
    run_case(100, 64, "zero chunks");
    chk("R6 abs err", int'(err), 1);
    run_case(512, 16, "err clears");
  endtask

  task automatic t_busy_ignore();
    launch(4096, 224);
    chk("R7 busy", int'(busy), 1);
    repeat (5) @(negedge clk);
    launch(2048, 64);
    page = 16'd1024; spare = 16'd1018;
    wait_done();
    check_outputs(4096, 224, "R8 ignore");
  endtask

  task automatic t_hold();
    int s0, b0;
    run_case(8192, 640, "hold base");
    s0 = int'(strength); b0 = int'(mbyte);
    page = 16'd1024; spare = 16'd1018;
    repeat (30) @(negedge clk);
    chk("R9 hold strength", int'(strength), s0);
    chk("R9 hold byte", int'(mbyte), b0);
    chk("R9 no busy", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R7 global watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_known();
    t_in_ecc();
    t_err();
    t_busy_ignore();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule